// File: doc/BRIEF.md
# Mixed-Width True Dual-Port RAM

This block is a synchronous memory with two fully independent ports. Each port has its own clock, active-low synchronous output reset, enable, write enable, address, write data and registered read data. Both ports look at one shared array of 1024 words of 18 bits: 16 data bits and 2 parity bits per word, 18,432 bits in total. The parity bits are stored and returned but never checked or generated.

Each port's width is set by a parameter to 1, 2, 4, 9 or 18 bits. A narrower port simply has more addresses, so the two ports may view the same bits through different shapes and convert data width with no extra logic. Only the 9-bit and 18-bit shapes reach the parity bits. Each port also has a parameter that sets what its output shows on a write: the new data, the data that was overwritten, or the unchanged previous output. Tying the top address bit of one port low and of the other port high splits the array into two independent half-size memories.

Read and write results appear at the port's data output one clock edge after the access. When one port reads a location in the same edge that the other port writes it, the read returns the contents from before that write. Two writes to the same bits in the same edge leave those bits undefined, and users must avoid that case.

Top module: `tdpr_ram`

## Requirements
- R1: A port of width 1, 2, 4, 9 or 18 has 16384, 8192, 4096, 2048 or 1024 addresses (address width `LOG2_WORDS` plus 4, 3, 2, 1 or 0 bits), and every address up to the last is usable. Each write changes exactly as many stored bits as the port is wide.
- R2: For widths 1, 2 and 4, address `a` reaches data bits `[(a mod n)*w +: w]` of word `a / n`, where n = 16/w. A 9-bit access at address `a` reaches data byte `a mod 2` of word `a / 2`, with its data on port bits [7:0]. An 18-bit access reaches data bits [15:0] of the word on port bits [15:0]. Lower addresses therefore select less significant slices.
- R3: Parity bits are reached only through the top bits of 9-bit and 18-bit ports. For a 9-bit access, port bit [8] is stored parity bit 16 + (a mod 2). For an 18-bit access, port bits [17:16] are stored parity bits [17:16]. Writes through a 1-, 2- or 4-bit port never change parity bits.
- R4: With enable high and write enable low, the output after the edge shows the stored contents at the address.
- R5: With enable low, the output holds its value and the memory is not written, whatever the other inputs are.
- R6: A port in new-data mode shows the data just written on its output after a write.
- R7: A port in old-data mode shows the contents from before the write on its output after a write.
- R8: A port in hold mode keeps its previous output value across a write.
- R9: A low reset at a clock edge clears that port's output to zero. It leaves the stored contents unchanged and does not stop a write made in the same edge.
- R10: Both ports can access the memory in the same edge. A read on one port of a location that the other port writes in that edge returns the contents from before the write.
- R11: With the top address bit of port A held low and that of port B held high, each port reaches only its own half of the words, and neither port disturbs the other half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| rst_n_a | input | 1 | Port A synchronous active-low output reset |
| en_a | input | 1 | Port A access enable |
| we_a | input | 1 | Port A write enable, used when enabled |
| addr_a | input | LOG2_WORDS + log2(16/data bits of WIDTH_A) | Port A address |
| din_a | input | WIDTH_A | Port A write data |
| dout_a | output | WIDTH_A | Port A registered read data |
| clk_b | input | 1 | Port B clock |
| rst_n_b | input | 1 | Port B synchronous active-low output reset |
| en_b | input | 1 | Port B access enable |
| we_b | input | 1 | Port B write enable, used when enabled |
| addr_b | input | LOG2_WORDS + log2(16/data bits of WIDTH_B) | Port B address |
| din_b | input | WIDTH_B | Port B write data |
| dout_b | output | WIDTH_B | Port B registered read data |

## Verification
Checks that run on every cycle cover the local rules of the output register of each port. The output holds while the port is disabled. On a read or a write, the output shows the written data, the read value or the unchanged value, according to the port's mode. The bit count of each write is also checked. Bit placement across mixed shapes, the parity bits staying out of reach of narrow ports, the old-data result of a read that meets a write from the other port, and the independence of the two halves of a split memory all depend on where data lands in the shared array. Only the bench's scenarios show these, by writing through one shape and reading back through another.

// File: rtl/tdpr_pkg.sv
`timescale 1ns/1ps
// Package tdpr_pkg
// Holds the shared types and the shape arithmetic of the mixed-width memory.
// Assumes a word of 16 data bits plus 2 parity bits, and port widths 1/2/4/9/18.
package tdpr_pkg;

    typedef enum logic [1:0] {
        RDW_NEW  = 2'd0,   // output shows the written data
        RDW_OLD  = 2'd1,   // output shows the overwritten data
        RDW_HOLD = 2'd2    // output keeps its previous value
    } rdw_mode_e;

    localparam int WORD_BITS = 18;
    localparam int DATA_BITS = 16;

    // Data bits carried by one access of a port of width w.
    function automatic int slice_data_bits(int w);
        if (w == 18) return 16;
        if (w == 9)  return 8;
        return w;
    endfunction

    // Number of slices of one word seen by a port of width w.
    function automatic int slice_count(int w);
        return DATA_BITS / slice_data_bits(w);
    endfunction

    // Address bits that pick a slice inside one word.
    function automatic int sel_bits(int w);
        return $clog2(slice_count(w));
    endfunction

    // Full address width of a port of width w over 2**lw words.
    function automatic int addr_bits(int w, int lw);
        return lw + sel_bits(w);
    endfunction

    function automatic bit width_ok(int w);
        return (w == 1) || (w == 2) || (w == 4) || (w == 9) || (w == 18);
    endfunction

    // Word bit that holds port bit i for slice sel: data bits first, parity on top.
    function automatic int bit_slot(int w, int sel, int i);
        int db;
        int pb;
        db = slice_data_bits(w);
        pb = w - db;
        if (i < db) return sel * db + i;
        return DATA_BITS + sel * pb + (i - db);
    endfunction

endpackage

// File: rtl/tdpr_bank.sv
`timescale 1ns/1ps
// Module tdpr_bank
// One storage bank of words with one masked write port and two
// combinational read ports. The top module holds two banks, and each
// bank is written by one port only. A stored value is the XOR of the
// two banks, so no storage bit has two writers in different clock domains.
// Assumes the writer supplies bits already combined with the other bank.
module tdpr_bank import tdpr_pkg::*; #(
    parameter int LOG2_WORDS = 10
) (
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic [LOG2_WORDS-1:0] wr_addr,
    input  logic [WORD_BITS-1:0]  wr_mask,
    input  logic [WORD_BITS-1:0]  wr_bits,
    input  logic [LOG2_WORDS-1:0] rd_addr_0,
    output logic [WORD_BITS-1:0]  rd_word_0,
    input  logic [LOG2_WORDS-1:0] rd_addr_1,
    output logic [WORD_BITS-1:0]  rd_word_1
);

    localparam int WORDS = 1 << LOG2_WORDS;

    logic [WORD_BITS-1:0] mem [WORDS];

    // Masked write: only the bits of the addressed slice change.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= (mem[wr_addr] & ~wr_mask) | (wr_bits & wr_mask);
            AST_WRITE_WIDTH: assert ($countones(wr_mask) == 1 || $countones(wr_mask) == 2 ||
                                     $countones(wr_mask) == 4 || $countones(wr_mask) == 9 ||
                                     $countones(wr_mask) == 18); // R1
        end
    end

    // Read ports see the current contents with no latency.
    assign rd_word_0 = mem[rd_addr_0];
    assign rd_word_1 = mem[rd_addr_1];

endmodule

// File: rtl/tdpr_port.sv
`timescale 1ns/1ps
// Module tdpr_port
// One access port of the memory. It splits the address into a word
// index and a slice select, places the port bits in the word (data low,
// parity high), builds the masked write for its own bank, and registers
// the read data according to the read-during-write mode.
// Assumes own_word and peer_word are both read at word_addr.
module tdpr_port import tdpr_pkg::*; #(
    parameter int        WIDTH      = 18,
    parameter int        LOG2_WORDS = 10,
    parameter rdw_mode_e MODE       = RDW_NEW,
    localparam int       SW         = sel_bits(WIDTH),
    localparam int       AW         = addr_bits(WIDTH, LOG2_WORDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  we,
    input  logic [AW-1:0]         addr,
    input  logic [WIDTH-1:0]      din,
    input  logic [WORD_BITS-1:0]  own_word,
    input  logic [WORD_BITS-1:0]  peer_word,
    output logic [LOG2_WORDS-1:0] word_addr,
    output logic                  wr_en,
    output logic [WORD_BITS-1:0]  wr_mask,
    output logic [WORD_BITS-1:0]  wr_bits,
    output logic [WIDTH-1:0]      dout
);

    logic [3:0]           sel;
    logic [WORD_BITS-1:0] merged;
    logic [WIDTH-1:0]     rd_val;

    // Address split: the low bits pick the slice, the rest pick the word.
    if (SW > 0) begin : g_sel
        assign sel       = 4'(addr[SW-1:0]);
        assign word_addr = addr[AW-1:SW];
    end else begin : g_nosel
        assign sel       = '0;
        assign word_addr = addr;
    end

    assign wr_en  = en & we;
    assign merged = own_word ^ peer_word;

    // Bit placement: gather the read slice and build the write mask and bits.
    always_comb begin
        rd_val  = '0;
        wr_mask = '0;
        wr_bits = '0;
        for (int i = 0; i < WIDTH; i++) begin
            rd_val[i] = merged[5'(bit_slot(WIDTH, int'(sel), i))];
            wr_mask[5'(bit_slot(WIDTH, int'(sel), i))] = 1'b1;
            wr_bits[5'(bit_slot(WIDTH, int'(sel), i))] =
                din[i] ^ peer_word[5'(bit_slot(WIDTH, int'(sel), i))];
        end
    end

    // Output register: reset, hold when idle, mode-dependent value on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (en) begin
            if (!we) begin
                dout <= rd_val;
            end else if (MODE == RDW_NEW) begin
                dout <= din;
            end else if (MODE == RDW_OLD) begin
                dout <= rd_val;
            end
        end
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(dout)); // R5

    AST_READ_SHOWS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        en && !we |=> dout == $past(rd_val)); // R4

    if (MODE == RDW_NEW) begin : g_ast_new
        AST_WRITE_SHOWS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
            en && we |=> dout == $past(din)); // R6
    end else if (MODE == RDW_OLD) begin : g_ast_old
        AST_WRITE_SHOWS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
            en && we |=> dout == $past(rd_val)); // R7
    end else begin : g_ast_hold
        AST_WRITE_KEEPS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
            en && we |=> $stable(dout)); // R8
    end

endmodule

// File: rtl/tdpr_ram.sv
`timescale 1ns/1ps
// Module tdpr_ram
// Mixed-width true dual-port RAM. Each port has its own clock and
// picks its width (1/2/4/9/18) and read-during-write mode by parameter.
// Both ports view one array of 2**LOG2_WORDS words of 16 data + 2 parity bits.
// Storage is two banks, each written by one port. A word is the XOR of both.
// Assumes users never write the same bits from both ports in one edge.
module tdpr_ram import tdpr_pkg::*; #(
    parameter int        WIDTH_A    = 18,
    parameter int        WIDTH_B    = 9,
    parameter rdw_mode_e MODE_A     = RDW_NEW,
    parameter rdw_mode_e MODE_B     = RDW_OLD,
    parameter int        LOG2_WORDS = 10
) (
    input  logic                                   clk_a,
    input  logic                                   rst_n_a,
    input  logic                                   en_a,
    input  logic                                   we_a,
    input  logic [addr_bits(WIDTH_A, LOG2_WORDS)-1:0] addr_a,
    input  logic [WIDTH_A-1:0]                     din_a,
    output logic [WIDTH_A-1:0]                     dout_a,
    input  logic                                   clk_b,
    input  logic                                   rst_n_b,
    input  logic                                   en_b,
    input  logic                                   we_b,
    input  logic [addr_bits(WIDTH_B, LOG2_WORDS)-1:0] addr_b,
    input  logic [WIDTH_B-1:0]                     din_b,
    output logic [WIDTH_B-1:0]                     dout_b
);

    if (!width_ok(WIDTH_A) || !width_ok(WIDTH_B)) begin : g_bad_width
        $error("tdpr_ram: port width must be 1, 2, 4, 9 or 18");
    end

    logic [LOG2_WORDS-1:0] word_a, word_b;
    logic                  wen_a, wen_b;
    logic [WORD_BITS-1:0]  mask_a, mask_b, bits_a, bits_b;
    logic [WORD_BITS-1:0]  bank_a_at_a, bank_a_at_b, bank_b_at_a, bank_b_at_b;

    // Bank written only by port A.
    tdpr_bank #(.LOG2_WORDS(LOG2_WORDS)) u_bank_a (
        .clk       (clk_a),
        .wr_en     (wen_a),
        .wr_addr   (word_a),
        .wr_mask   (mask_a),
        .wr_bits   (bits_a),
        .rd_addr_0 (word_a),
        .rd_word_0 (bank_a_at_a),
        .rd_addr_1 (word_b),
        .rd_word_1 (bank_a_at_b)
    );

    // Bank written only by port B.
    tdpr_bank #(.LOG2_WORDS(LOG2_WORDS)) u_bank_b (
        .clk       (clk_b),
        .wr_en     (wen_b),
        .wr_addr   (word_b),
        .wr_mask   (mask_b),
        .wr_bits   (bits_b),
        .rd_addr_0 (word_a),
        .rd_word_0 (bank_b_at_a),
        .rd_addr_1 (word_b),
        .rd_word_1 (bank_b_at_b)
    );

    tdpr_port #(.WIDTH(WIDTH_A), .LOG2_WORDS(LOG2_WORDS), .MODE(MODE_A)) u_port_a (
        .clk       (clk_a),
        .rst_n     (rst_n_a),
        .en        (en_a),
        .we        (we_a),
        .addr      (addr_a),
        .din       (din_a),
        .own_word  (bank_a_at_a),
        .peer_word (bank_b_at_a),
        .word_addr (word_a),
        .wr_en     (wen_a),
        .wr_mask   (mask_a),
        .wr_bits   (bits_a),
        .dout      (dout_a)
    );

    tdpr_port #(.WIDTH(WIDTH_B), .LOG2_WORDS(LOG2_WORDS), .MODE(MODE_B)) u_port_b (
        .clk       (clk_b),
        .rst_n     (rst_n_b),
        .en        (en_b),
        .we        (we_b),
        .addr      (addr_b),
        .din       (din_b),
        .own_word  (bank_b_at_b),
        .peer_word (bank_a_at_b),
        .word_addr (word_b),
        .wr_en     (wen_b),
        .wr_mask   (mask_b),
        .wr_bits   (bits_b),
        .dout      (dout_b)
    );

endmodule

// File: tb/test_tdpr_ram.sv
`timescale 1ns/1ps
// Bench for tdpr_ram: three instances cover every width and mode. A
// behavioural model (bit arrays, integers) predicts every output and is
// compared on every clock.
module test_tdpr_ram;
    import tdpr_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        en_v [3][2];
    logic        we_v [3][2];
    logic        rst_v[3][2];
    logic [13:0] ad_v [3][2];
    logic [17:0] dn_v [3][2];
    logic [17:0] q00, q01, q10, q11, q20, q21;

    int wd [3][2] = '{'{18, 9}, '{2, 1}, '{4, 18}};
    int md [3][2] = '{'{0, 1}, '{2, 0}, '{1, 2}};   // 0 new, 1 old, 2 hold
    int lw [3]    = '{10, 4, 4};

    logic [17:0] mdl [3][1024];
    logic [17:0] expq[3][2];
    int    checks = 0;
    int    errors = 0;
    bit    chk_on = 0;
    bit    done   = 0;
    string cur_req = "R9";

    tdpr_ram #(.WIDTH_A(18), .WIDTH_B(9), .MODE_A(RDW_NEW), .MODE_B(RDW_OLD), .LOG2_WORDS(10)) i_tdpr_ram (
        .clk_a(clk), .rst_n_a(rst_v[0][0]), .en_a(en_v[0][0]), .we_a(we_v[0][0]),
        .addr_a(ad_v[0][0][9:0]), .din_a(dn_v[0][0][17:0]), .dout_a(q00[17:0]),
        .clk_b(clk), .rst_n_b(rst_v[0][1]), .en_b(en_v[0][1]), .we_b(we_v[0][1]),
        .addr_b(ad_v[0][1][10:0]), .din_b(dn_v[0][1][8:0]), .dout_b(q01[8:0]));

    tdpr_ram #(.WIDTH_A(2), .WIDTH_B(1), .MODE_A(RDW_HOLD), .MODE_B(RDW_NEW), .LOG2_WORDS(4)) i_tdpr_ram_s (
        .clk_a(clk), .rst_n_a(rst_v[1][0]), .en_a(en_v[1][0]), .we_a(we_v[1][0]),
        .addr_a(ad_v[1][0][6:0]), .din_a(dn_v[1][0][1:0]), .dout_a(q10[1:0]),
        .clk_b(clk), .rst_n_b(rst_v[1][1]), .en_b(en_v[1][1]), .we_b(we_v[1][1]),
        .addr_b(ad_v[1][1][7:0]), .din_b(dn_v[1][1][0:0]), .dout_b(q11[0:0]));

    tdpr_ram #(.WIDTH_A(4), .WIDTH_B(18), .MODE_A(RDW_OLD), .MODE_B(RDW_HOLD), .LOG2_WORDS(4)) i_tdpr_ram_t (
        .clk_a(clk), .rst_n_a(rst_v[2][0]), .en_a(en_v[2][0]), .we_a(we_v[2][0]),
        .addr_a(ad_v[2][0][5:0]), .din_a(dn_v[2][0][3:0]), .dout_a(q20[3:0]),
        .clk_b(clk), .rst_n_b(rst_v[2][1]), .en_b(en_v[2][1]), .we_b(we_v[2][1]),
        .addr_b(ad_v[2][1][3:0]), .din_b(dn_v[2][1][17:0]), .dout_b(q21[17:0]));

    // Shape rules taken from the requirements (R1, R2, R3).
    function automatic int dbits(int w);
        return (w == 18) ? 16 : ((w == 9) ? 8 : w);
    endfunction
    function automatic int nslc(int w);
        return 16 / dbits(w);
    endfunction
    function automatic int word_of(int w, int a);
        return a / nslc(w);
    endfunction
    function automatic int slot(int w, int a, int i);
        int s;
        s = a % nslc(w);
        if (i < dbits(w)) return s * dbits(w) + i;
        return 16 + s * (w - dbits(w)) + (i - dbits(w));
    endfunction
    function automatic int naddr(int d, int p);
        return (1 << lw[d]) * nslc(wd[d][p]);
    endfunction
    function automatic logic [17:0] wmask(int w);
        logic [17:0] m;
        m = '0;
        for (int i = 0; i < w; i++) m[i] = 1'b1;
        return m;
    endfunction
    function automatic logic [17:0] mread(int d, int p, int a);
        logic [17:0] r;
        r = '0;
        for (int i = 0; i < wd[d][p]; i++) r[i] = mdl[d][word_of(wd[d][p], a)][slot(wd[d][p], a, i)];
        return r;
    endfunction
    function automatic logic [17:0] qval(int d, int p);
        case (d * 2 + p)
            0: return q00;
            1: return q01;
            2: return q10;
            3: return q11;
            4: return q20;
            default: return q21;
        endcase
    endfunction

    // Model of one clock edge: all reads first, then all writes.
    task automatic model_edge();
        logic [17:0] rv[3][2];
        for (int d = 0; d < 3; d++)
            for (int p = 0; p < 2; p++)
                rv[d][p] = mread(d, p, int'(ad_v[d][p]));
        for (int d = 0; d < 3; d++)
            for (int p = 0; p < 2; p++) begin
                if (!rst_v[d][p]) expq[d][p] = '0;
                else if (en_v[d][p]) begin
                    if (!we_v[d][p]) expq[d][p] = rv[d][p];
                    else if (md[d][p] == 0) expq[d][p] = dn_v[d][p] & wmask(wd[d][p]);
                    else if (md[d][p] == 1) expq[d][p] = rv[d][p];
                end
            end
        for (int d = 0; d < 3; d++)
            for (int p = 0; p < 2; p++)
                if (en_v[d][p] && we_v[d][p])
                    for (int i = 0; i < wd[d][p]; i++)
                        mdl[d][word_of(wd[d][p], int'(ad_v[d][p]))][slot(wd[d][p], int'(ad_v[d][p]), i)] = dn_v[d][p][i];
    endtask

    task automatic compare();
        logic [17:0] m;
        for (int d = 0; d < 3; d++)
            for (int p = 0; p < 2; p++) begin
                m = wmask(wd[d][p]);
                checks++;
                if ((qval(d, p) & m) !== (expq[d][p] & m)) begin
                    errors++;
                    $display("FAIL %s dut%0d port%0d: actual %h expected %h", cur_req, d, p,
                             qval(d, p) & m, expq[d][p] & m);
                end
            end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (chk_on) compare();
    endtask

    task automatic idle();
        for (int d = 0; d < 3; d++)
            for (int p = 0; p < 2; p++) begin
                en_v[d][p]  = 1'b0;
                we_v[d][p]  = 1'b0;
                rst_v[d][p] = 1'b1;
            end
    endtask

    task automatic op(int d, int p, bit w, int a, logic [17:0] v);
        en_v[d][p] = 1'b1;
        we_v[d][p] = w;
        ad_v[d][p] = 14'(a);
        dn_v[d][p] = v & wmask(wd[d][p]);
    endtask

    initial begin
        for (int d = 0; d < 3; d++)
            for (int p = 0; p < 2; p++) begin
                en_v[d][p] = 1'b0; we_v[d][p] = 1'b0; rst_v[d][p] = 1'b0;
                ad_v[d][p] = '0;   dn_v[d][p] = '0;   expq[d][p]  = 'x;
            end
        // R9: reset state of every output
        cur_req = "R9";
        cycle();
        chk_on = 1;
        cycle();
        cycle();
        idle();
        // R6: fill all three memories; DUT0 port A shows each written word
        cur_req = "R6";
        for (int i = 0; i < 1024; i++) begin
            idle();
            op(0, 0, 1, i, 18'($urandom));
            if (i < 128) op(1, 0, 1, i, 18'($urandom));
            if (i < 16)  op(2, 1, 1, i, 18'($urandom));
            cycle();
        end
        // R4: plain reads on all ports
        cur_req = "R4";
        idle();
        op(0, 0, 0, 3, 0); op(0, 1, 0, 7, 0); op(1, 0, 0, 5, 0);
        op(1, 1, 0, 9, 0); op(2, 0, 0, 11, 0); op(2, 1, 0, 2, 0);
        cycle();
        // R2: write through one shape, read through the other
        cur_req = "R2";
        idle(); op(0, 1, 1, 19, 18'h1A5); op(1, 1, 1, 53, 18'h1); cycle();
        idle(); op(0, 0, 0, 9, 0); op(0, 1, 0, 18, 0); op(1, 0, 0, 26, 0); op(1, 1, 0, 52, 0); cycle();
        // R3: narrow write leaves parity bits as they were
        cur_req = "R3";
        idle(); op(2, 0, 1, 23, 18'hC); cycle();
        idle(); op(2, 1, 0, 5, 0); op(0, 1, 1, 33, 18'h0FF); cycle();
        idle(); op(0, 0, 0, 16, 0); cycle();
        // R5: disabled ports ignore write enable, address and data
        cur_req = "R5";
        for (int k = 0; k < 2; k++) begin
            idle();
            for (int d = 0; d < 3; d++)
                for (int p = 0; p < 2; p++) begin
                    op(d, p, 1, 1 + k, 18'h2AAAA);
                    en_v[d][p] = 1'b0;
                end
            cycle();
        end
        idle();
        for (int d = 0; d < 3; d++)
            for (int p = 0; p < 2; p++) op(d, p, 0, 2, 0);
        cycle();
        // R6: new-data ports
        cur_req = "R6";
        idle(); op(0, 0, 1, 44, 18'h3C3C3); op(1, 1, 1, 77, 18'h1); cycle();
        idle(); cycle();
        // R7: old-data ports
        cur_req = "R7";
        idle(); op(0, 1, 1, 100, 18'h155); op(2, 0, 1, 7, 18'h9); cycle();
        idle(); op(0, 1, 0, 100, 0); op(2, 0, 0, 7, 0); cycle();
        // R8: hold ports
        cur_req = "R8";
        idle(); op(1, 0, 0, 41, 0); op(2, 1, 0, 4, 0); cycle();
        idle(); op(1, 0, 1, 40, 18'h2); op(2, 1, 1, 3, 18'h12345); cycle();
        idle(); op(1, 0, 0, 40, 0); op(2, 1, 0, 3, 0); cycle();
        // R9: reset clears output only; write in reset edge still lands
        cur_req = "R9";
        idle(); op(0, 0, 0, 9, 0); rst_v[0][0] = 1'b0; op(2, 1, 1, 6, 18'h0F0F0); rst_v[2][1] = 1'b0; cycle();
        idle(); op(0, 0, 0, 9, 0); op(2, 1, 0, 6, 0); cycle();
        // R10: read meets a write from the other port in the same edge
        cur_req = "R10";
        idle(); op(0, 0, 1, 20, 18'h0BEEF); op(0, 1, 0, 40, 0); cycle();
        idle(); op(0, 1, 0, 40, 0); op(0, 0, 0, 20, 0); cycle();
        // R11: split into halves by the top address bit
        cur_req = "R11";
        idle(); op(0, 0, 1, 5, 18'h11111); op(0, 1, 1, 1024 + 11, 18'h0AA); cycle();
        idle(); op(0, 0, 0, 5, 0); op(0, 1, 0, 1024 + 11, 0); cycle();
        idle(); op(0, 0, 0, 517, 0); op(0, 1, 0, 11, 0); cycle();
        // R1: highest address of every shape
        cur_req = "R1";
        idle();
        op(0, 0, 1, 1023, 18'h3FFFF); op(1, 1, 1, 255, 18'h1); op(2, 0, 1, 63, 18'h5);
        cycle();
        idle();
        op(0, 1, 0, 2047, 0); op(1, 0, 0, 127, 0); op(2, 1, 0, 15, 0);
        cycle();
        // R10: random concurrent traffic, no same-word writes from both ports
        cur_req = "R10";
        for (int k = 0; k < 300; k++) begin
            idle();
            for (int d = 0; d < 3; d++)
                for (int p = 0; p < 2; p++)
                    if ($urandom % 4 != 0)
                        op(d, p, bit'($urandom % 2), int'($urandom % naddr(d, p)), 18'($urandom));
            for (int d = 0; d < 3; d++) begin
                if (en_v[d][0] && we_v[d][0] && en_v[d][1] && we_v[d][1] &&
                    word_of(wd[d][0], int'(ad_v[d][0])) == word_of(wd[d][1], int'(ad_v[d][1])))
                    we_v[d][1] = 1'b0;
                if ($urandom % 32 == 0) rst_v[d][$urandom % 2] = 1'b0;
            end
            cycle();
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog %s: actual cycles 200000 expected fewer", cur_req);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule